// File: doc/BRIEF.md
# DMA Register Read-Back Sequencer

This block supplies the data byte for successive processor reads of a DMA controller's register port. Software programs a 7-bit read mask that selects any subset of seven register bytes: a status byte, the two bytes of the transfer byte counter, and the two bytes of each of the two port address counters. Successive read strobes then walk through the selected bytes in a fixed order and start again from the first after the last.

The status byte is built from a fixed pattern with four live condition bits. These are engine enabled, ready mismatch, no match yet, and block not finished. The list of selected bytes is rebuilt with its position set to the first entry in three cases: a new mask is written, an explicit restart command arrives, or a status-only command replaces the mask with the status selection. Every byte is taken from the live inputs at the moment its read strobe is sampled, so reading the same list twice can return different values. The counters themselves are owned by other logic and only observed here.

Top module: `dma_rdback_seq`

## Requirements
- R1: After reset `rd_data` is 0x38, the stored mask is zero and the list is empty.
- R2: The status byte is 0xCC with bit 0 set when `eng_en` is 1, bit 4 set when `match_hit` is 0 and bit 5 set when `blk_done` is 0; any bits above bit 7 are zero.
- R3: Status bit 1 is set only when `mode` is not 1 and `rdy_in` differs from `rdy_pol`; with `mode` equal to 1 it is always 0.
- R4: Mask bit i selects source i. The order is 0 status, 1 byte counter low, 2 byte counter high, 3 port A address low, 4 port A address high, 5 port B address low, 6 port B address high. Selected sources are listed in ascending bit order, and mask bits above bit 6 are ignored.
- R5: Each cycle with `rd_stb` high loads `rd_data` at that clock edge with the byte at the current list position and moves to the next position. After the last entry the position goes back to the first.
- R6: A cycle with `mask_wr` high stores `mask_din[6:0]` as the mask, rebuilds the list from it and sets the position to the first entry.
- R7: A cycle with `seq_start` high rebuilds the list from the stored mask and sets the position to the first entry.
- R8: A cycle with `stat_only` high, and `mask_wr` low, stores mask 0x01 and rebuilds the list, so that reads return only the status byte.
- R9: A read while the list is empty returns the status byte computed from the inputs in that cycle.
- R10: A listed byte is taken from the live inputs in the cycle of its read strobe, not from the values present when the list was built.
- R11: `rd_data` keeps its value in every cycle without a read strobe.
- R12: The commands have a fixed priority: `mask_wr` over `stat_only` over `seq_start`. A read in the same cycle as a rebuild returns the byte at the old list position, and the next read starts from the first entry of the new list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb | input | 1 | One read of the register port in this cycle |
| mask_wr | input | 1 | Store `mask_din` as the read mask and rebuild the list |
| mask_din | input | BYTE_W | Mask byte; bits 6..0 are used |
| seq_start | input | 1 | Rebuild the list from the stored mask |
| stat_only | input | 1 | Replace the mask with status only and rebuild |
| eng_en | input | 1 | Transfer engine enabled |
| mode | input | MODE_W | Current transfer mode |
| rdy_in | input | 1 | Present level of the ready line |
| rdy_pol | input | 1 | Programmed active level of ready |
| match_hit | input | 1 | A byte match has occurred |
| blk_done | input | 1 | End of block reached |
| byte_cnt | input | CNT_W | Transfer byte counter |
| addr_a | input | CNT_W | Port A address counter |
| addr_b | input | CNT_W | Port B address counter |
| rd_data | output | BYTE_W | Byte returned by the latest read |

## Verification
The bench goes after the list wrap: a position that does not return to the first entry reads a wrong byte or a stale one after the last listed byte. It also covers rebuilds that arrive in the middle of a list, where a design that keeps the old position reads from the wrong place. Sparse masks with bit 7 set are used, where a wrong compaction returns bytes out of order or a byte that was not selected. Command collisions check that a wrong priority stores the wrong mask. Live values changed between reads of one list show a design that freezes bytes at build time. The ready-mismatch bit is checked under mode 1, where a design that ignores the mode sets the bit wrongly.

// File: rtl/dma_rb_pkg.sv
package dma_rb_pkg;
   localparam int unsigned NSRC  = 7;
   localparam int unsigned SRC_W = 3;
   localparam int unsigned LEN_W = 3;
   localparam int unsigned NSLOT = 1 << LEN_W;

   typedef enum logic [SRC_W-1:0] {
      SRC_STAT  = 3'd0,
      SRC_CNT_L = 3'd1,
      SRC_CNT_H = 3'd2,
      SRC_A_L   = 3'd3,
      SRC_A_H   = 3'd4,
      SRC_B_L   = 3'd5,
      SRC_B_H   = 3'd6
   } src_e;

   localparam logic [7:0]      STAT_BASE  = 8'hCC;
   localparam logic [7:0]      STAT_RESET = 8'h38;
   localparam logic [NSRC-1:0] MASK_STAT  = 7'h01;
endpackage

// File: rtl/dma_rb_status.sv
module dma_rb_status #(
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned MODE_W    = 2,
   parameter int unsigned PASS_MODE = 1
) (
   input  logic              eng_en,
   input  logic [MODE_W-1:0] mode,
   input  logic              rdy_in,
   input  logic              rdy_pol,
   input  logic              match_hit,
   input  logic              blk_done,
   output logic [BYTE_W-1:0] stat
);
   import dma_rb_pkg::*;

   localparam logic [MODE_W-1:0] PASS_M = MODE_W'(PASS_MODE);

   if (BYTE_W < 8) begin : g_bad_width
      $error("dma_rb_status: BYTE_W must be at least 8");
   end

   always_comb begin
      stat      = '0;
      stat[7:0] = STAT_BASE;
      stat[0]   = eng_en;
      stat[1]   = (mode != PASS_M) && (rdy_in != rdy_pol);
      stat[4]   = ~match_hit;
      stat[5]   = ~blk_done;
   end
endmodule

// File: rtl/dma_rb_list.sv
module dma_rb_list #(
   parameter int unsigned LIST_IMPL = 0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       rebuild,
   input  logic [dma_rb_pkg::NSRC-1:0] new_mask,
   input  logic                       adv,
   output dma_rb_pkg::src_e           cur_src,
   output logic                       cur_valid
);
   import dma_rb_pkg::*;

   logic [LEN_W-1:0] len_q, ptr_q, len_nxt;

   if (LIST_IMPL > 1) begin : g_bad_impl
      $error("dma_rb_list: LIST_IMPL must be 0 (table) or 1 (scan)");
   end

   assign len_nxt   = LEN_W'($countones(new_mask));
   assign cur_valid = (len_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q <= '0;
         ptr_q <= '0;
      end else if (rebuild) begin
         len_q <= len_nxt;
         ptr_q <= '0;
      end else if (adv && cur_valid) begin
         ptr_q <= (ptr_q == len_q - 1'b1) ? '0 : ptr_q + 1'b1;
      end
   end

   if (LIST_IMPL == 0) begin : g_table
      src_e             tbl_q   [NSLOT];
      src_e             tbl_nxt [NSLOT];
      logic [LEN_W-1:0] fill_k;

      always_comb begin
         fill_k = '0;
         for (int i = 0; i < NSLOT; i++) tbl_nxt[i] = SRC_STAT;
         for (int i = 0; i < NSRC; i++) begin
            if (new_mask[i]) begin
               tbl_nxt[fill_k] = src_e'(SRC_W'(i));
               fill_k          = fill_k + 1'b1;
            end
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) tbl_q[i] <= SRC_STAT;
         end else if (rebuild) begin
            for (int i = 0; i < NSLOT; i++) tbl_q[i] <= tbl_nxt[i];
         end
      end

      assign cur_src = tbl_q[ptr_q];
   end else begin : g_scan
      logic [NSRC-1:0]  mask_q;
      logic [LEN_W-1:0] seen;

      always_ff @(posedge clk) begin
         if (!rst_n)       mask_q <= '0;
         else if (rebuild) mask_q <= new_mask;
      end

      always_comb begin
         cur_src = SRC_STAT;
         seen    = '0;
         for (int i = 0; i < NSRC; i++) begin
            if (mask_q[i]) begin
               if (seen == ptr_q) cur_src = src_e'(SRC_W'(i));
               seen = seen + 1'b1;
            end
         end
      end
   end

   // R5: position stays inside the list, and is zero for an empty list
   p_ptr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cur_valid ? (ptr_q < len_q) : (ptr_q == '0));

   // R5: a read at the last entry goes back to the first
   p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!rebuild && adv && cur_valid && ptr_q == len_q - 1'b1) |=> (ptr_q == '0));

   // R6 / R7: any rebuild restarts at the first entry
   p_rebuild_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rebuild |=> (ptr_q == '0));
endmodule

// File: rtl/dma_rb_mux.sv
module dma_rb_mux #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned CNT_W  = 16
) (
   input  dma_rb_pkg::src_e   src,
   input  logic [BYTE_W-1:0]  stat,
   input  logic [CNT_W-1:0]   byte_cnt,
   input  logic [CNT_W-1:0]   addr_a,
   input  logic [CNT_W-1:0]   addr_b,
   output logic [BYTE_W-1:0]  sel_byte
);
   import dma_rb_pkg::*;

   logic [BYTE_W-1:0] cnt_l, cnt_h, a_l, a_h, b_l, b_h;

   assign cnt_l = BYTE_W'(byte_cnt);
   assign cnt_h = BYTE_W'(byte_cnt >> BYTE_W);
   assign a_l   = BYTE_W'(addr_a);
   assign a_h   = BYTE_W'(addr_a >> BYTE_W);
   assign b_l   = BYTE_W'(addr_b);
   assign b_h   = BYTE_W'(addr_b >> BYTE_W);

   always_comb begin
      unique case (src)
         SRC_STAT:  sel_byte = stat;
         SRC_CNT_L: sel_byte = cnt_l;
         SRC_CNT_H: sel_byte = cnt_h;
         SRC_A_L:   sel_byte = a_l;
         SRC_A_H:   sel_byte = a_h;
         SRC_B_L:   sel_byte = b_l;
         SRC_B_H:   sel_byte = b_h;
         default:   sel_byte = stat;
      endcase
   end
endmodule

// File: rtl/dma_rdback_seq.sv
module dma_rdback_seq #(
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned MODE_W    = 2,
   parameter int unsigned PASS_MODE = 1,
   parameter int unsigned LIST_IMPL = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_stb,
   input  logic              mask_wr,
   input  logic [BYTE_W-1:0] mask_din,
   input  logic              seq_start,
   input  logic              stat_only,
   input  logic              eng_en,
   input  logic [MODE_W-1:0] mode,
   input  logic              rdy_in,
   input  logic              rdy_pol,
   input  logic              match_hit,
   input  logic              blk_done,
   input  logic [CNT_W-1:0]  byte_cnt,
   input  logic [CNT_W-1:0]  addr_a,
   input  logic [CNT_W-1:0]  addr_b,
   output logic [BYTE_W-1:0] rd_data
);
   import dma_rb_pkg::*;

   if (BYTE_W < 8) begin : g_bad_byte
      $error("dma_rdback_seq: BYTE_W must be at least 8");
   end
   if (CNT_W <= BYTE_W || CNT_W > 2 * BYTE_W) begin : g_bad_cnt
      $error("dma_rdback_seq: CNT_W must lie in (BYTE_W, 2*BYTE_W]");
   end
   if (PASS_MODE >= (1 << MODE_W)) begin : g_bad_mode
      $error("dma_rdback_seq: PASS_MODE does not fit MODE_W");
   end

   logic [NSRC-1:0]   mask_q, mask_nxt;
   logic              rebuild;
   logic [BYTE_W-1:0] stat_byte, list_byte;
   src_e              cur_src;
   logic              lst_valid;

   assign rebuild = mask_wr | stat_only | seq_start;

   always_comb begin
      if (mask_wr)        mask_nxt = mask_din[NSRC-1:0];
      else if (stat_only) mask_nxt = MASK_STAT;
      else                mask_nxt = mask_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_nxt;
   end

   dma_rb_status #(
      .BYTE_W(BYTE_W), .MODE_W(MODE_W), .PASS_MODE(PASS_MODE)
   ) u_status (
      .eng_en(eng_en), .mode(mode), .rdy_in(rdy_in), .rdy_pol(rdy_pol),
      .match_hit(match_hit), .blk_done(blk_done), .stat(stat_byte)
   );

   dma_rb_list #(.LIST_IMPL(LIST_IMPL)) u_list (
      .clk(clk), .rst_n(rst_n), .rebuild(rebuild), .new_mask(mask_nxt),
      .adv(rd_stb), .cur_src(cur_src), .cur_valid(lst_valid)
   );

   dma_rb_mux #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_mux (
      .src(cur_src), .stat(stat_byte), .byte_cnt(byte_cnt),
      .addr_a(addr_a), .addr_b(addr_b), .sel_byte(list_byte)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      rd_data <= BYTE_W'(STAT_RESET);
      else if (rd_stb) rd_data <= lst_valid ? list_byte : stat_byte;
   end

   // R11: no read strobe, no change on the data byte
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> $stable(rd_data));

   // R9: an empty list returns the status computed in the read cycle
   p_empty_stat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !lst_valid) |=> (rd_data == $past(stat_byte)));

   // R6: a mask write stores the low seven bits
   p_mask_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr |=> (mask_q == $past(mask_din[NSRC-1:0])));

   // R8: status-only command leaves only the status selected
   p_stat_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_only && !mask_wr) |=> (mask_q == MASK_STAT && lst_valid));
endmodule

// File: tb/dma_rdback_seq_tb.sv
module dma_rdback_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        rd_stb, mask_wr, seq_start, stat_only;
   logic [7:0]  mask_din;
   logic        eng_en, rdy_in, rdy_pol, match_hit, blk_done;
   logic [1:0]  mode;
   logic [15:0] byte_cnt, addr_a, addr_b;
   logic [7:0]  rd_data, rd_data_s;

   int total = 0;
   int bad   = 0;

   logic [6:0] m_mask;
   int         m_ptr;
   logic [7:0] m_exp;

   always #10 clk = ~clk;

   dma_rdback_seq #(.LIST_IMPL(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .mask_wr(mask_wr),
      .mask_din(mask_din), .seq_start(seq_start), .stat_only(stat_only),
      .eng_en(eng_en), .mode(mode), .rdy_in(rdy_in), .rdy_pol(rdy_pol),
      .match_hit(match_hit), .blk_done(blk_done), .byte_cnt(byte_cnt),
      .addr_a(addr_a), .addr_b(addr_b), .rd_data(rd_data)
   );

   dma_rdback_seq #(.LIST_IMPL(1)) u_dut_scan (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .mask_wr(mask_wr),
      .mask_din(mask_din), .seq_start(seq_start), .stat_only(stat_only),
      .eng_en(eng_en), .mode(mode), .rdy_in(rdy_in), .rdy_pol(rdy_pol),
      .match_hit(match_hit), .blk_done(blk_done), .byte_cnt(byte_cnt),
      .addr_a(addr_a), .addr_b(addr_b), .rd_data(rd_data_s)
   );

   function automatic logic [7:0] stat_f();
      logic [7:0] s;
      s = 8'hCC;
      if (eng_en) s = s | 8'h01;
      if (mode != 2'd1 && rdy_in != rdy_pol) s = s | 8'h02;
      if (!match_hit) s = s | 8'h10;
      if (!blk_done)  s = s | 8'h20;
      return s;
   endfunction

   function automatic logic [7:0] src_f(int idx);
      case (idx)
         0: return stat_f();
         1: return byte_cnt[7:0];
         2: return byte_cnt[15:8];
         3: return addr_a[7:0];
         4: return addr_a[15:8];
         5: return addr_b[7:0];
         default: return addr_b[15:8];
      endcase
   endfunction

   function automatic int nth_f(logic [6:0] m, int n);
      int seen = 0;
      for (int i = 0; i < 7; i++) begin
         if (m[i]) begin
            if (seen == n) return i;
            seen++;
         end
      end
      return 0;
   endfunction

   task automatic chk(string tag);
      total++;
      if (rd_data !== m_exp) begin
         bad++;
         $display("FAIL %s: rd_data=%02h expected=%02h", tag, rd_data, m_exp);
      end
      total++;
      if (rd_data_s !== m_exp) begin
         bad++;
         $display("FAIL %s (scan variant): rd_data=%02h expected=%02h", tag, rd_data_s, m_exp);
      end
   endtask

   // inputs are set; advance model, clock once, check at the falling edge
   task automatic tick(string tag);
      int len = $countones(m_mask);
      if (rd_stb) begin
         if (len == 0) m_exp = stat_f();
         else begin
            m_exp = src_f(nth_f(m_mask, m_ptr));
            m_ptr = (m_ptr + 1 >= len) ? 0 : m_ptr + 1;
         end
      end
      if (mask_wr) begin
         m_mask = mask_din[6:0]; m_ptr = 0;
      end else if (stat_only) begin
         m_mask = 7'h01; m_ptr = 0;
      end else if (seq_start) begin
         m_ptr = 0;
      end
      @(posedge clk);
      @(negedge clk);
      chk(tag);
      rd_stb = 0; mask_wr = 0; seq_start = 0; stat_only = 0;
   endtask

   task automatic rd(string tag);
      rd_stb = 1; tick(tag);
   endtask

   task automatic wmask(logic [7:0] v, string tag);
      mask_wr = 1; mask_din = v; tick(tag);
   endtask

   initial begin
      #(20 * 100000);
      total++; bad++;
      $display("FAIL watchdog: run did not end");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 0; rd_stb = 0; mask_wr = 0; seq_start = 0; stat_only = 0;
      mask_din = 0; eng_en = 0; mode = 0; rdy_in = 0; rdy_pol = 0;
      match_hit = 0; blk_done = 0;
      byte_cnt = 16'hA1B2; addr_a = 16'hC3D4; addr_b = 16'hE5F6;
      m_mask = 0; m_ptr = 0; m_exp = 8'h38;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      rst_n = 1;
      chk("R1 reset value");
      // R1 / R9: empty list after reset returns live status
      rd("R1 R9 empty list read");
      // R2 status bit combinations
      eng_en = 1; match_hit = 1; blk_done = 1; rd("R2 status en, match, end");
      eng_en = 0; match_hit = 0; blk_done = 1; rd("R2 status no match");
      blk_done = 0; rd("R2 status block running");
      // R3 ready mismatch depends on mode
      rdy_in = 1; rdy_pol = 0; mode = 2'd0; rd("R3 mode0 mismatch");
      mode = 2'd1; rd("R3 mode1 suppresses");
      mode = 2'd3; rd("R3 mode3 mismatch");
      rdy_pol = 1; rd("R3 levels equal");
      // R4 / R5 full list with wrap
      wmask(8'h7F, "R6 full mask write");
      for (int k = 0; k < 9; k++) rd("R4 R5 full list order and wrap");
      // R4 sparse mask, bit 7 ignored
      wmask(8'hA2, "R4 sparse mask write");
      for (int k = 0; k < 4; k++) rd("R4 sparse order, bit7 ignored");
      // R7 restart mid-list
      wmask(8'h78, "R6 mask write");
      rd("R7 before restart"); rd("R7 before restart");
      seq_start = 1; tick("R7 restart");
      rd("R7 first after restart"); rd("R7 second after restart");
      // R6 mask write mid-list
      wmask(8'h06, "R6 rewrite mid-list");
      rd("R6 first after rewrite");
      // R10 live sampling
      wmask(8'h08, "R10 mask A low");
      addr_a = 16'h1234; rd("R10 first sample");
      addr_a = 16'h5678; rd("R10 value changed after build");
      // R8 status only, with live status
      stat_only = 1; tick("R8 status-only command");
      rd("R8 status read"); eng_en = 1; rd("R8 R10 live status");
      // R11 hold
      byte_cnt = 16'h0000; tick("R11 hold no read"); tick("R11 hold again");
      // R12 collisions
      wmask(8'h7E, "R12 setup");
      rd("R12 advance");
      rd_stb = 1; mask_wr = 1; mask_din = 8'h30; stat_only = 1; seq_start = 1;
      tick("R12 read with all commands");
      rd("R12 new list first");
      rd_stb = 1; stat_only = 1; seq_start = 1; tick("R12 stat_only over seq_start");
      rd("R12 status-only list");
      // random phase
      for (int k = 0; k < 4000; k++) begin
         eng_en    = $urandom_range(0, 1);
         mode      = 2'($urandom_range(0, 3));
         rdy_in    = $urandom_range(0, 1);
         rdy_pol   = $urandom_range(0, 1);
         match_hit = $urandom_range(0, 1);
         blk_done  = $urandom_range(0, 1);
         byte_cnt  = 16'($urandom);
         addr_a    = 16'($urandom);
         addr_b    = 16'($urandom);
         rd_stb    = ($urandom_range(0, 99) < 55);
         mask_wr   = ($urandom_range(0, 99) < 7);
         mask_din  = 8'($urandom);
         stat_only = ($urandom_range(0, 99) < 3);
         seq_start = ($urandom_range(0, 99) < 4);
         tick("R5 R12 random mix");
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule